// File: doc/BRIEF.md
# Cache Way Maintenance Engine

This block is the control side of a set-associative second-level cache, with no tag or data storage behind it. Software starts a whole-cache maintenance pass by writing a bitmask of ways to one of three operation registers: invalidate, clean, or clean-and-invalidate. The engine walks the selected ways one at a time, lowest index first. It drives a strobe and a way index toward the arrays for a fixed number of cycles per way. When a way is finished, it clears that way's bit. Software polls the operation register until it reads zero.

Around the engine sit four other registers. A geometry register selects 8 or 16 ways and sets the way size. An enable register can only be written by secure accesses. A sync register reports busy until the engine has drained. A bank of lockdown masks holds an instruction mask and a data mask for each of eight masters. Replacement logic queries the lockdown bank through a side port. Lockdown has no effect on maintenance: locked ways are walked like any others.

The engine is a three-state machine. **IDLE** waits for a start. The transition *start* is taken on a write of a nonzero in-range mask to an operation register, and it loads the pending mask. **PICK** latches the lowest pending way and then always takes the transition *go* to WALK. **WALK** asserts the strobe for `CYCLES_PER_WAY` cycles and then clears the way's bit. From WALK, the transition *next* returns to PICK if bits remain, and the transition *done* returns to IDLE if none remain.

Top module: `waymaint_top`

## Requirements
- R1: After reset, every register reads zero except the geometry register, which reads 8 ways and 16 KB. The strobe is low and `lk_ways` is zero.
- R2: The geometry register (0x08) returns the way count in bits [7:0] and the way size in KB in bits [31:16]. The way count is (associativity bit + 1) × 8. The way size is 16 KB when the size field is 0 or 1, and 16 KB × 2^(s−1) for a field value s ≥ 1. The settings register (0x04) holds the associativity bit in bit 8 and the size field in bits [2:0].
- R3: A write of a mask to an operation register is ANDed with the valid way mask: 0x00FF for 8 ways, 0xFFFF for 16 ways. The operation registers are invalidate (0x10), clean (0x14) and clean-and-invalidate (0x18). While the operation runs, a read of its register returns the bits still pending.
- R4: Ways are processed one at a time, lowest set bit first. Each way takes one PICK cycle with the strobe low, then `CYCLES_PER_WAY` cycles with `maint_strobe` high. During those cycles `maint_way` holds the way index and `maint_op` holds the operation code: 1 for invalidate, 2 for clean, 3 for clean-and-invalidate.
- R5: The running operation's register reads zero once every selected way is finished. The other two operation registers read zero throughout.
- R6: A write to any operation register while an operation is in progress is ignored.
- R7: The enable register is at 0x00, with the enable in bit 0. A write to it without `bus_secure` gives `bus_err` high in the following cycle and leaves the register unchanged. A secure write updates it with no error.
- R8: A write to the settings register is ignored while the enable bit is set.
- R9: Lockdown masks sit at 0x40 + 8·master for data and 0x44 + 8·master for instruction, for masters 0 to 7. Each mask is independent of the others and reads back as written. `lk_ways` returns the mask selected by `lk_master` and `lk_instr`.
- R10: Lockdown masks do not change which ways a maintenance operation walks.
- R11: A write to the sync register (0x0C) sets busy, which reads as bit 0 there. Busy stays set while an operation is in progress and clears once the engine is idle.
- R12: A write whose masked value is zero starts nothing. The engine stays idle and can accept a new start on the next write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data returned next cycle |
| bus_wdata | input | 32 | Write data |
| bus_secure | input | 1 | Secure attribute of the access |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | Error response for a rejected write, one cycle after it |
| lk_master | input | 3 | Master whose lockdown is queried |
| lk_instr | input | 1 | 1 selects the instruction mask, 0 the data mask |
| lk_ways | output | 16 | Selected lockdown mask |
| maint_strobe | output | 1 | Current way is being processed |
| maint_op | output | 2 | Running operation code |
| maint_way | output | 4 | Way under maintenance |
| cache_en | output | 1 | Enable bit |

## Verification
The bench builds the block with `CYCLES_PER_WAY` set to 3. A full 16-way pass then lasts 64 cycles, so the behavioural reference can follow every strobe cycle of 8-way and 16-way walks well within the run time. A sparse mask with gaps and high bits exercises ordering. The short walk also lets the bench place ignored writes, reads of the idle registers and sync requests inside a running pass, and then poll the pass to completion.

// File: rtl/waymaint_pkg.sv
package waymaint_pkg;
    localparam int unsigned WM_MAX_WAYS  = 16;
    localparam int unsigned WM_WAY_IDX_W = $clog2(WM_MAX_WAYS);
    localparam int unsigned WM_MASTERS   = 8;
    localparam int unsigned WM_MST_W     = $clog2(WM_MASTERS);
    localparam int unsigned WM_ADDR_W    = 8;
    localparam int unsigned WM_DATA_W    = 32;
    localparam int unsigned WM_SIZE_W    = 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_INV   = 2'd1,
        OP_CLEAN = 2'd2,
        OP_CLINV = 2'd3
    } wm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PICK = 2'd1,
        ST_WALK = 2'd2
    } wm_state_e;

    localparam logic [WM_ADDR_W-1:0] A_CTRL  = 8'h00;
    localparam logic [WM_ADDR_W-1:0] A_CFG   = 8'h04;
    localparam logic [WM_ADDR_W-1:0] A_GEOM  = 8'h08;
    localparam logic [WM_ADDR_W-1:0] A_SYNC  = 8'h0C;
    localparam logic [WM_ADDR_W-1:0] A_INV   = 8'h10;
    localparam logic [WM_ADDR_W-1:0] A_CLEAN = 8'h14;
    localparam logic [WM_ADDR_W-1:0] A_CLINV = 8'h18;

    function automatic logic [WM_WAY_IDX_W-1:0] wm_lowest(input logic [WM_MAX_WAYS-1:0] v);
        logic [WM_WAY_IDX_W-1:0] idx;
        idx = '0;
        for (int i = WM_MAX_WAYS - 1; i >= 0; i--) begin
            if (v[i]) idx = WM_WAY_IDX_W'(i);
        end
        return idx;
    endfunction
endpackage

// File: rtl/waymaint_cfg.sv
module waymaint_cfg
    import waymaint_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_ctrl,
    input  logic                    wr_cfg,
    input  logic                    secure,
    input  logic                    en_in,
    input  logic                    assoc_in,
    input  logic [WM_SIZE_W-1:0]    size_in,
    output logic                    enable,
    output logic                    assoc,
    output logic [WM_SIZE_W-1:0]    size_fld,
    output logic [WM_MAX_WAYS-1:0]  valid_mask,
    output logic [7:0]              way_count,
    output logic [15:0]             size_kb,
    output logic                    ctrl_err
);
    localparam int unsigned BASE_WAYS = WM_MAX_WAYS / 2;

    logic [WM_SIZE_W-1:0] shamt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable   <= 1'b0;
            assoc    <= 1'b0;
            size_fld <= '0;
            ctrl_err <= 1'b0;
        end else begin
            ctrl_err <= wr_ctrl && !secure;
            if (wr_ctrl && secure) enable <= en_in;
            if (wr_cfg && !enable) begin
                assoc    <= assoc_in;
                size_fld <= size_in;
            end
        end
    end

    assign way_count = {3'd0, ({1'b0, assoc} + 2'd1), 3'd0};
    assign shamt     = (size_fld == '0) ? '0 : size_fld - 1'b1;
    assign size_kb   = 16'd16 << shamt;

    for (genvar i = 0; i < WM_MAX_WAYS; i++) begin : g_vmask
        if (i < BASE_WAYS) begin : g_low
            assign valid_mask[i] = 1'b1;
        end else begin : g_high
            assign valid_mask[i] = assoc;
        end
    end
endmodule

// File: rtl/waymaint_lock.sv
module waymaint_lock
    import waymaint_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [WM_MST_W-1:0]    wr_mst,
    input  logic                   wr_instr,
    input  logic [WM_MAX_WAYS-1:0] wr_mask,
    input  logic [WM_MST_W-1:0]    rd_mst,
    input  logic                   rd_instr,
    output logic [WM_MAX_WAYS-1:0] rd_mask,
    input  logic [WM_MST_W-1:0]    q_mst,
    input  logic                   q_instr,
    output logic [WM_MAX_WAYS-1:0] q_mask
);
    localparam int unsigned N_ENTRIES = WM_MASTERS * 2;

    logic [WM_MAX_WAYS-1:0] lk_w [N_ENTRIES];

    for (genvar m = 0; m < WM_MASTERS; m++) begin : g_mst
        for (genvar k = 0; k < 2; k++) begin : g_kind
            logic [WM_MAX_WAYS-1:0] mask_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mask_q <= '0;
                end else if (wr_en && wr_mst == WM_MST_W'(m) && wr_instr == 1'(k)) begin
                    mask_q <= wr_mask;
                end
            end
            assign lk_w[m*2+k] = mask_q;
        end
    end

    assign rd_mask = lk_w[{rd_mst, rd_instr}];
    assign q_mask  = lk_w[{q_mst, q_instr}];
endmodule

// File: rtl/waymaint_engine.sv
module waymaint_engine
    import waymaint_pkg::*;
#(
    parameter int unsigned CYCLES_PER_WAY = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  wm_op_e                  start_op,
    input  logic [WM_MAX_WAYS-1:0]  start_mask,
    input  logic                    sync_wr,
    output logic                    busy,
    output wm_op_e                  cur_op,
    output logic [WM_MAX_WAYS-1:0]  pending,
    output logic                    strobe,
    output logic [WM_WAY_IDX_W-1:0] way,
    output logic                    sync_busy
);
    localparam int unsigned CNT_W = (CYCLES_PER_WAY > 1) ? $clog2(CYCLES_PER_WAY) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES_PER_WAY - 1);
    localparam logic [WM_MAX_WAYS-1:0] ONE = WM_MAX_WAYS'(1);

    wm_state_e              state_q, state_d;
    logic [WM_MAX_WAYS-1:0] pending_q, remaining;
    wm_op_e                 op_q;
    logic [WM_WAY_IDX_W-1:0] way_q;
    logic [CNT_W-1:0]       cnt_q;
    logic                   sync_q;
    logic                   last_beat, take_start;

    assign last_beat  = (cnt_q == LAST);
    assign remaining  = pending_q & ~(ONE << way_q);
    assign take_start = start && (start_mask != '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions: start, go, next, done
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (take_start) state_d = ST_PICK;
            ST_PICK: state_d = ST_WALK;
            ST_WALK: if (last_beat) state_d = (remaining == '0) ? ST_IDLE : ST_PICK;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending_q <= '0;
            op_q      <= OP_NONE;
            way_q     <= '0;
            cnt_q     <= '0;
            sync_q    <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take_start) begin
                        pending_q <= start_mask;
                        op_q      <= start_op;
                    end
                end
                ST_PICK: begin
                    way_q <= wm_lowest(pending_q);
                    cnt_q <= '0;
                end
                ST_WALK: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_beat) begin
                        pending_q <= remaining;
                        if (remaining == '0) op_q <= OP_NONE;
                    end
                end
                default: ;
            endcase
            if (sync_wr)                  sync_q <= 1'b1;
            else if (state_q == ST_IDLE)  sync_q <= 1'b0;
        end
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        strobe    = (state_q == ST_WALK);
        way       = way_q;
        cur_op    = op_q;
        pending   = pending_q;
        sync_busy = sync_q;
    end
endmodule

// File: rtl/waymaint_top.sv
module waymaint_top
    import waymaint_pkg::*;
#(
    parameter int unsigned CYCLES_PER_WAY = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [31:0] bus_wdata,
    input  logic        bus_secure,
    output logic [31:0] bus_rdata,
    output logic        bus_err,
    input  logic [2:0]  lk_master,
    input  logic        lk_instr,
    output logic [15:0] lk_ways,
    output logic        maint_strobe,
    output logic [1:0]  maint_op,
    output logic [3:0]  maint_way,
    output logic        cache_en
);
    logic                    cfg_assoc;
    logic [WM_SIZE_W-1:0]    cfg_size;
    logic [WM_MAX_WAYS-1:0]  valid_mask;
    logic [7:0]              way_count;
    logic [15:0]             size_kb;
    logic                    lock_region, is_op_addr;
    logic [WM_MAX_WAYS-1:0]  lock_rd;
    wm_op_e                  wr_op, eng_op;
    logic                    eng_busy, eng_sync_busy;
    logic [WM_MAX_WAYS-1:0]  eng_pending;
    logic [31:0]             rd_word, rdata_q;
    logic                    unused_hi;

    assign unused_hi   = ^bus_wdata[31:16];
    assign lock_region = (bus_addr[7:6] == 2'b01);

    always_comb begin
        unique case (bus_addr)
            A_INV:   wr_op = OP_INV;
            A_CLEAN: wr_op = OP_CLEAN;
            A_CLINV: wr_op = OP_CLINV;
            default: wr_op = OP_NONE;
        endcase
        is_op_addr = (wr_op != OP_NONE);
    end

    waymaint_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (bus_wr && bus_addr == A_CTRL),
        .wr_cfg    (bus_wr && bus_addr == A_CFG),
        .secure    (bus_secure),
        .en_in     (bus_wdata[0]),
        .assoc_in  (bus_wdata[8]),
        .size_in   (bus_wdata[2:0]),
        .enable    (cache_en),
        .assoc     (cfg_assoc),
        .size_fld  (cfg_size),
        .valid_mask(valid_mask),
        .way_count (way_count),
        .size_kb   (size_kb),
        .ctrl_err  (bus_err)
    );

    waymaint_lock u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (bus_wr && lock_region),
        .wr_mst  (bus_addr[5:3]),
        .wr_instr(bus_addr[2]),
        .wr_mask (bus_wdata[15:0]),
        .rd_mst  (bus_addr[5:3]),
        .rd_instr(bus_addr[2]),
        .rd_mask (lock_rd),
        .q_mst   (lk_master),
        .q_instr (lk_instr),
        .q_mask  (lk_ways)
    );

    waymaint_engine #(.CYCLES_PER_WAY(CYCLES_PER_WAY)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (bus_wr && is_op_addr),
        .start_op  (wr_op),
        .start_mask(bus_wdata[15:0] & valid_mask),
        .sync_wr   (bus_wr && bus_addr == A_SYNC),
        .busy      (eng_busy),
        .cur_op    (eng_op),
        .pending   (eng_pending),
        .strobe    (maint_strobe),
        .way       (maint_way),
        .sync_busy (eng_sync_busy)
    );

    assign maint_op = eng_op;

    always_comb begin
        rd_word = '0;
        if (lock_region) begin
            rd_word = {16'd0, lock_rd};
        end else if (is_op_addr) begin
            rd_word = (eng_busy && eng_op == wr_op) ? {16'd0, eng_pending} : '0;
        end else begin
            unique case (bus_addr)
                A_CTRL:  rd_word = {31'd0, cache_en};
                A_CFG:   rd_word = {23'd0, cfg_assoc, 5'd0, cfg_size};
                A_GEOM:  rd_word = {size_kb, 8'd0, way_count};
                A_SYNC:  rd_word = {31'd0, eng_sync_busy};
                default: rd_word = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= bus_rd ? rd_word : '0;
    end

    assign bus_rdata = rdata_q;
endmodule

// File: rtl/waymaint_chk.sv
module waymaint_chk
    import waymaint_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [7:0]              bus_addr,
    input logic                    bus_wr,
    input logic                    bus_secure,
    input logic                    bus_err,
    input logic                    cache_en,
    input logic                    busy,
    input logic [WM_MAX_WAYS-1:0]  pending,
    input logic [WM_MAX_WAYS-1:0]  valid_mask,
    input logic                    strobe,
    input logic [WM_WAY_IDX_W-1:0] way,
    input logic                    sync_busy,
    input logic                    cfg_assoc,
    input logic [WM_SIZE_W-1:0]    cfg_size
);
    AST_START_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((pending & ~valid_mask) == '0)); // R3

    AST_WAY_STILL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> pending[way]); // R4

    AST_NO_NEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ((pending & ~$past(pending)) == '0)); // R6

    AST_CTRL_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CTRL && !bus_secure) |=> (bus_err && $stable(cache_en))); // R7

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_CFG && cache_en) |=> ($stable(cfg_assoc) && $stable(cfg_size))); // R8

    AST_SYNC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_busy && busy) |=> sync_busy); // R11
endmodule

bind waymaint_top waymaint_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_secure(bus_secure),
    .bus_err   (bus_err),
    .cache_en  (cache_en),
    .busy      (eng_busy),
    .pending   (eng_pending),
    .valid_mask(valid_mask),
    .strobe    (maint_strobe),
    .way       (maint_way),
    .sync_busy (eng_sync_busy),
    .cfg_assoc (cfg_assoc),
    .cfg_size  (cfg_size)
);

// File: tb/waymaint_tb_top.sv
`timescale 1ns/1ps
module waymaint_tb_top;
    localparam int CPW = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_secure = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [2:0]  lk_master = '0;
    logic        lk_instr = 1'b0;
    logic [15:0] lk_ways;
    logic        maint_strobe;
    logic [1:0]  maint_op;
    logic [3:0]  maint_way;
    logic        cache_en;

    always #2.5 clk = ~clk;

    waymaint_top #(.CYCLES_PER_WAY(CPW)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_secure(bus_secure), .bus_rdata(bus_rdata), .bus_err(bus_err),
        .lk_master(lk_master), .lk_instr(lk_instr), .lk_ways(lk_ways),
        .maint_strobe(maint_strobe), .maint_op(maint_op), .maint_way(maint_way), .cache_en(cache_en)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit run_cmp = 0;
    bit m_popped = 0;
    int exp_q[$];
    int cmp_e;
    logic [1:0] m_run_op = 2'd0;
    logic m_en = 0, m_assoc = 0;
    logic [2:0] m_size = 0;
    logic [15:0] m_lock [8][2];
    bit done = 0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
        $finish;
    endtask

    // per-clock reference comparison of the maintenance strobe (R4, R6, R10, R12)
    always @(posedge clk) begin
        #1;
        if (run_cmp) begin
            if (exp_q.size() > 0) begin
                cmp_e = exp_q.pop_front();
                m_popped = 1;
            end else begin
                cmp_e = -1;
                m_popped = 0;
            end
            n_checks++;
            if (cmp_e < 0) begin
                if (maint_strobe !== 1'b0) begin
                    n_fail++;
                    $display("FAIL R4 strobe actual=%b expected=0", maint_strobe);
                end
            end else if (maint_strobe !== 1'b1 || maint_way !== cmp_e[3:0] || maint_op !== m_run_op) begin
                n_fail++;
                $display("FAIL R4 strobe/way/op actual=%b/%0d/%0d expected=1/%0d/%0d",
                         maint_strobe, maint_way, maint_op, cmp_e, m_run_op);
            end
        end
    end

    function automatic logic [15:0] vmask();
        return m_assoc ? 16'hFFFF : 16'h00FF;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic sec, output logic err);
        logic [15:0] msk;
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_secure = sec; bus_wr = 1'b1;
        @(posedge clk);
        // reference model update at the accepting edge
        if (a == 8'h00 && sec) m_en = d[0];
        if (a == 8'h04 && !m_en) begin m_assoc = d[8]; m_size = d[2:0]; end
        if (a[7:6] == 2'b01) m_lock[a[5:3]][a[2]] = d[15:0];
        if ((a == 8'h10 || a == 8'h14 || a == 8'h18) && !m_popped && exp_q.size() == 0) begin
            msk = d[15:0] & vmask();
            if (msk != 0) begin
                m_run_op = (a == 8'h10) ? 2'd1 : (a == 8'h14) ? 2'd2 : 2'd3;
                for (int w = 0; w < 16; w++) begin
                    if (msk[w]) begin
                        exp_q.push_back(-1);
                        for (int c = 0; c < CPW; c++) exp_q.push_back(w);
                    end
                end
            end
        end
        #1;
        err = bus_err;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk);
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic poll_zero(input logic [7:0] a, input string req);
        logic [31:0] d;
        d = 32'hFFFF_FFFF;
        for (int i = 0; i < 300; i++) begin
            rd(a, d);
            if (d == 0) break;
        end
        check(req, d, 32'd0);
    endtask

    function automatic logic [31:0] geom_exp();
        int sh;
        sh = (m_size == 0) ? 0 : m_size - 1;
        return {16'(16 << sh), 8'd0, 8'(m_assoc ? 16 : 8)};
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [31:0] d;
        logic e;
        for (int m = 0; m < 8; m++) begin m_lock[m][0] = 0; m_lock[m][1] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        run_cmp = 1;

        // R1: reset state
        rd(8'h00, d); check("R1 ctrl", d, 0);
        rd(8'h04, d); check("R1 cfg", d, 0);
        rd(8'h08, d); check("R1 geom", d, {16'd16, 8'd0, 8'd8});
        rd(8'h0C, d); check("R1 sync", d, 0);
        rd(8'h10, d); check("R1 inv", d, 0);
        rd(8'h4C, d); check("R1 lock", d, 0);
        check("R1 lk_ways", {16'd0, lk_ways}, 0);

        // R2: geometry decode for several field values
        wr(8'h04, 32'h0000_0103, 1'b1, e);
        rd(8'h08, d); check("R2 geom 16 ways s3", d, geom_exp());
        wr(8'h04, 32'h0000_0001, 1'b1, e);
        rd(8'h08, d); check("R2 geom 8 ways s1", d, geom_exp());
        wr(8'h04, 32'h0000_0007, 1'b1, e);
        rd(8'h08, d); check("R2 geom s7", d, geom_exp());
        wr(8'h04, 32'h0000_0000, 1'b1, e);
        rd(8'h08, d); check("R2 geom s0", d, {16'd16, 8'd0, 8'd8});

        // R3, R5, R6: 8-way invalidate with out-of-range bits
        wr(8'h10, 32'h0000_FFFF, 1'b0, e);
        rd(8'h10, d); check("R3 pending masked", d, 32'h0000_00FF);
        rd(8'h14, d); check("R5 other op reads zero", d, 0);
        wr(8'h14, 32'h0000_0003, 1'b0, e);
        rd(8'h14, d); check("R6 write while busy ignored", d, 0);
        poll_zero(8'h10, "R5 invalidate done");

        // R4: sparse 16-way clean, lowest first
        wr(8'h04, 32'h0000_0100, 1'b1, e);
        wr(8'h14, 32'h0000_A005, 1'b0, e);
        rd(8'h14, d); check("R4 clean pending", d, 32'h0000_A005);
        poll_zero(8'h14, "R5 clean done");

        // R12: zero mask and out-of-range-only mask start nothing
        wr(8'h18, 32'h0000_0000, 1'b0, e);
        rd(8'h18, d); check("R12 zero mask", d, 0);
        wr(8'h04, 32'h0000_0000, 1'b1, e);
        wr(8'h18, 32'h0000_FF00, 1'b0, e);
        rd(8'h18, d); check("R12 high-only mask", d, 0);
        wr(8'h10, 32'h0000_0010, 1'b0, e);
        poll_zero(8'h10, "R12 next start accepted");

        // R9: lockdown per master and kind
        wr(8'h58, 32'h0000_00F0, 1'b0, e);
        wr(8'h5C, 32'h0000_0F0F, 1'b0, e);
        wr(8'h68, 32'h0000_FFFF, 1'b1, e);
        rd(8'h58, d); check("R9 m3 data", d, {16'd0, m_lock[3][0]});
        rd(8'h5C, d); check("R9 m3 instr", d, {16'd0, m_lock[3][1]});
        rd(8'h6C, d); check("R9 m5 instr untouched", d, 0);
        @(negedge clk); lk_master = 3'd3; lk_instr = 1'b1; #1;
        check("R9 lk_ways m3 instr", {16'd0, lk_ways}, {16'd0, m_lock[3][1]});
        @(negedge clk); lk_master = 3'd5; lk_instr = 1'b0; #1;
        check("R9 lk_ways m5 data", {16'd0, lk_ways}, {16'd0, m_lock[5][0]});

        // R10: locked ways still walked
        wr(8'h18, 32'h0000_00FF, 1'b0, e);
        rd(8'h18, d); check("R10 all ways pending", d, 32'h0000_00FF);
        poll_zero(8'h18, "R10 clean-invalidate done");

        // R7: enable needs secure access
        wr(8'h00, 32'h1, 1'b0, e);
        check("R7 nonsecure err", {31'd0, e}, 1);
        rd(8'h00, d); check("R7 ctrl unchanged", d, 0);
        wr(8'h00, 32'h1, 1'b1, e);
        check("R7 secure no err", {31'd0, e}, 0);
        rd(8'h00, d); check("R7 ctrl set", d, 1);
        check("R7 cache_en", {31'd0, cache_en}, 1);

        // R8: settings frozen while enabled
        wr(8'h04, 32'h0000_0105, 1'b1, e);
        rd(8'h04, d); check("R8 cfg unchanged", d, 0);
        rd(8'h08, d); check("R8 geom unchanged", d, {16'd16, 8'd0, 8'd8});
        wr(8'h00, 32'h0, 1'b1, e);

        // R11: sync busy
        wr(8'h10, 32'h0000_00FF, 1'b0, e);
        wr(8'h0C, 32'h0, 1'b0, e);
        rd(8'h0C, d); check("R11 sync busy while running", d, 1);
        poll_zero(8'h10, "R11 op drains");
        repeat (3) @(posedge clk);
        rd(8'h0C, d); check("R11 sync clears", d, 0);

        repeat (2) @(posedge clk);
        #2;
        check("R4 reference queue drained", exp_q.size(), 0);
        done = 1;
        finish_run();
    end
endmodule